// File: doc/BRIEF.md
# Multiplexed Bidirectional Bus Exchanger

The exchanger links one narrow port (A) to two ports of the same width, called B1 and B2. Together, B1 and B2 form a word twice as wide as A.

In the A-to-B direction, each B port is fed by its own capture register. A register samples A on a rising clock edge only while its active-low capture enable is asserted. By enabling the two registers in different cycles, two successive A words are placed side by side and presented on B as one double-width word.

In the B-to-A direction, each B port feeds its own transparent latch. A latch follows its input while its active-low latch control is low and keeps its value while that control is high. A select input chooses which latch drives A.

Each pin that can be driven from inside the block appears as three signals: an input, an output and an output-enable. The A side and the B side each have an active-low drive enable.

Top module: `bus_xchg`

## Requirements
- R1: On a rising clock edge with `rst` low and `cap1_n` low, the B1 register takes `a_in`. The new value is seen on `b1_out` right after that edge. `cap2_n` does the same for `b2_out`.
- R2: On a rising clock edge with `rst` low and a capture enable high, that register keeps its contents.
- R3: The two capture enables act independently. Word X captured with only `cap1_n` low, then word Y captured with only `cap2_n` low, gives `{b2_out,b1_out}` = `{Y,X}`. Both enables low in one cycle load both registers with the same word.
- R4: While `hold1_n` is low, the B1 latch follows `b1_in`. While `hold2_n` is low, the B2 latch follows `b2_in`.
- R5: While a latch control is high, that latch keeps its value whatever its B input does.
- R6: `a_out` carries the B1 latch when `sel_b1` is 1 and the B2 latch when `sel_b1` is 0.
- R7: `a_oe` equals the inverse of `a_en_n`. `b1_oe` and `b2_oe` both equal the inverse of `b_en_n`. All four enable combinations are legal and leave the data paths unchanged.
- R8: A rising edge with `rst` high clears both capture registers to zero. Reset leaves both latches unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the capture registers |
| rst | input | 1 | Synchronous active-high reset of the capture registers |
| a_in | input | W | Word arriving on port A |
| a_out | output | W | Word driven onto port A |
| a_oe | output | 1 | Drive enable for port A |
| a_en_n | input | 1 | Active-low A-side drive enable |
| b_en_n | input | 1 | Active-low B-side drive enable |
| cap1_n | input | 1 | Active-low capture enable, B1 register |
| cap2_n | input | 1 | Active-low capture enable, B2 register |
| b1_in | input | W | Word arriving on port B1 |
| b1_out | output | W | Word driven onto port B1 |
| b1_oe | output | 1 | Drive enable for port B1 |
| b2_in | input | W | Word arriving on port B2 |
| b2_out | output | W | Word driven onto port B2 |
| b2_oe | output | 1 | Drive enable for port B2 |
| hold1_n | input | 1 | B1 latch control, low = transparent |
| hold2_n | input | 1 | B2 latch control, low = transparent |
| sel_b1 | input | 1 | 1 routes the B1 latch to A, 0 routes the B2 latch |

## Verification
The B outputs are due right after the first rising edge that follows a stimulus. The A output and all the drive enables are combinational, so they are due in the same cycle as the stimulus.

The driver applies each stimulus on a falling edge and queues the values expected after the next rising edge. The monitor samples three nanoseconds after that rising edge, which covers both the registered and the combinational results. The latch model in the bench updates only when its control is low, so hold behaviour is checked at `a_out` with the select steering the held latch.

// File: rtl/bus_xchg_pkg.sv
package bus_xchg_pkg;
  parameter int unsigned DEF_W = 12;
  parameter int unsigned NUM_B = 2;
  typedef enum logic {PICK_B2 = 1'b0, PICK_B1 = 1'b1} pick_e;
endpackage

// File: rtl/bus_xchg_cap.sv
module bus_xchg_cap #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ce_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)        q <= '0;
    else if (!ce_n) q <= d;
  end

  p_load_r1: assert property (@(posedge clk) disable iff (rst)
    !ce_n |=> q == $past(d));
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    ce_n |=> $stable(q));
  p_clear_r8: assert property (@(posedge clk)
    rst |=> q == '0);
endmodule

// File: rtl/bus_xchg_latch.sv
module bus_xchg_latch #(
  parameter int unsigned W = 12
) (
  input  logic         le_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_latch begin
    if (!le_n) q = d;
  end
endmodule

// File: rtl/bus_xchg_mux.sv
module bus_xchg_mux
  import bus_xchg_pkg::*;
#(
  parameter int unsigned W = 12
) (
  input  logic         sel,
  input  logic [W-1:0] from_b1,
  input  logic [W-1:0] from_b2,
  output logic [W-1:0] y
);
  pick_e pick;
  assign pick = pick_e'(sel);
  always_comb begin
    case (pick)
      PICK_B1: y = from_b1;
      default: y = from_b2;
    endcase
  end
endmodule

// File: rtl/bus_xchg.sv
module bus_xchg
  import bus_xchg_pkg::*;
#(
  parameter int unsigned W = DEF_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  input  logic         a_en_n,
  input  logic         b_en_n,
  input  logic         cap1_n,
  input  logic         cap2_n,
  input  logic [W-1:0] b1_in,
  output logic [W-1:0] b1_out,
  output logic         b1_oe,
  input  logic [W-1:0] b2_in,
  output logic [W-1:0] b2_out,
  output logic         b2_oe,
  input  logic         hold1_n,
  input  logic         hold2_n,
  input  logic         sel_b1
);
  logic [NUM_B-1:0] ce_n_v;
  logic [NUM_B-1:0] le_n_v;
  logic [W-1:0]     b_d   [NUM_B];
  logic [W-1:0]     reg_q [NUM_B];
  logic [W-1:0]     lat_q [NUM_B];

  assign ce_n_v = {cap2_n, cap1_n};
  assign le_n_v = {hold2_n, hold1_n};
  assign b_d[0] = b1_in;
  assign b_d[1] = b2_in;

  for (genvar i = 0; i < NUM_B; i++) begin : g_lane
    bus_xchg_cap #(.W(W)) u_cap (
      .clk (clk),
      .rst (rst),
      .ce_n(ce_n_v[i]),
      .d   (a_in),
      .q   (reg_q[i])
    );
    bus_xchg_latch #(.W(W)) u_lat (
      .le_n(le_n_v[i]),
      .d   (b_d[i]),
      .q   (lat_q[i])
    );
  end

  bus_xchg_mux #(.W(W)) u_mux (
    .sel    (sel_b1),
    .from_b1(lat_q[0]),
    .from_b2(lat_q[1]),
    .y      (a_out)
  );

  assign b1_out = reg_q[0];
  assign b2_out = reg_q[1];
  assign a_oe   = ~a_en_n;
  assign b1_oe  = ~b_en_n;
  assign b2_oe  = ~b_en_n;

  p_follow1_r4: assert property (@(posedge clk) disable iff (rst)
    !hold1_n |-> lat_q[0] == b1_in);
  p_follow2_r4: assert property (@(posedge clk) disable iff (rst)
    !hold2_n |-> lat_q[1] == b2_in);
  p_keep1_r5: assert property (@(posedge clk) disable iff (rst)
    hold1_n && $past(hold1_n) |-> $stable(lat_q[0]));
  p_keep2_r5: assert property (@(posedge clk) disable iff (rst)
    hold2_n && $past(hold2_n) |-> $stable(lat_q[1]));
endmodule

// File: tb/bus_xchg_test.sv
module bus_xchg_test;
  localparam int W = 12;

  logic clk = 1'b0;
  logic rst, a_en_n, b_en_n, cap1_n, cap2_n, hold1_n, hold2_n, sel_b1;
  logic [W-1:0] a_in, b1_in, b2_in, a_out, b1_out, b2_out;
  logic a_oe, b1_oe, b2_oe;

  always #4 clk = ~clk;

  bus_xchg #(.W(W)) uut (
    .clk(clk), .rst(rst), .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .a_en_n(a_en_n), .b_en_n(b_en_n), .cap1_n(cap1_n), .cap2_n(cap2_n),
    .b1_in(b1_in), .b1_out(b1_out), .b1_oe(b1_oe),
    .b2_in(b2_in), .b2_out(b2_out), .b2_oe(b2_oe),
    .hold1_n(hold1_n), .hold2_n(hold2_n), .sel_b1(sel_b1)
  );

  typedef struct {
    string        req;
    logic [W-1:0] b1, b2, a;
    logic         aoe, boe;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  logic [W-1:0] m1 = '0, m2 = '0, l1 = '0, l2 = '0;

  task automatic chk(string req, string what, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic step(string req, logic r, logic [W-1:0] a, logic c1, logic c2,
                      logic [W-1:0] v1, logic [W-1:0] v2, logic h1, logic h2,
                      logic s, logic aen, logic ben);
    exp_t e;
    @(negedge clk);
    rst = r; a_in = a; cap1_n = c1; cap2_n = c2; b1_in = v1; b2_in = v2;
    hold1_n = h1; hold2_n = h2; sel_b1 = s; a_en_n = aen; b_en_n = ben;
    if (r) begin m1 = '0; m2 = '0; end
    else begin
      if (!c1) m1 = a;
      if (!c2) m2 = a;
    end
    if (!h1) l1 = v1;
    if (!h2) l2 = v2;
    e.req = req; e.b1 = m1; e.b2 = m2; e.a = s ? l1 : l2;
    e.aoe = ~aen; e.boe = ~ben;
    q.push_back(e);
  endtask

  always @(posedge clk) begin
    #3;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk(e.req, "b1_out", b1_out, e.b1);
      chk(e.req, "b2_out", b2_out, e.b2);
      chk(e.req, "a_out", a_out, e.a);
      chk(e.req, "a_oe", {{(W-1){1'b0}}, a_oe}, {{(W-1){1'b0}}, e.aoe});
      chk(e.req, "b1_oe", {{(W-1){1'b0}}, b1_oe}, {{(W-1){1'b0}}, e.boe});
      chk(e.req, "b2_oe", {{(W-1){1'b0}}, b2_oe}, {{(W-1){1'b0}}, e.boe});
    end
  end

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1; a_in = '0; cap1_n = 1; cap2_n = 1; b1_in = '0; b2_in = '0;
    hold1_n = 0; hold2_n = 0; sel_b1 = 1; a_en_n = 1; b_en_n = 1;
    // R8 reset state, latches made transparent
    step("R8", 1, 12'h5A5, 0, 0, 12'h011, 12'h022, 0, 0, 1, 1, 1);
    step("R8", 1, 12'h5A5, 0, 0, 12'h011, 12'h022, 0, 0, 0, 1, 1);
    // R1 R3: two words via alternating enables
    step("R1", 0, 12'hABC, 0, 1, 12'h011, 12'h022, 1, 1, 1, 0, 0);
    step("R3", 0, 12'h123, 1, 0, 12'h011, 12'h022, 1, 1, 1, 0, 0);
    // R2: both enables high, registers hold
    step("R2", 0, 12'hFFF, 1, 1, 12'h011, 12'h022, 1, 1, 1, 0, 0);
    step("R2", 0, 12'h000, 1, 1, 12'h011, 12'h022, 1, 1, 1, 0, 0);
    // R3: both enables low loads both
    step("R3", 0, 12'h777, 0, 0, 12'h011, 12'h022, 1, 1, 1, 0, 0);
    step("R1", 0, 12'h9E1, 1, 0, 12'h011, 12'h022, 1, 1, 1, 0, 0);
    // R4 R5 on B1
    step("R4", 0, 12'h000, 1, 1, 12'h3C3, 12'h022, 0, 1, 1, 0, 0);
    step("R4", 0, 12'h000, 1, 1, 12'hC3C, 12'h022, 0, 1, 1, 0, 0);
    step("R5", 0, 12'h000, 1, 1, 12'h111, 12'h022, 1, 1, 1, 0, 0);
    step("R5", 0, 12'h000, 1, 1, 12'h222, 12'h999, 1, 1, 1, 0, 0);
    // R4 R5 on B2
    step("R4", 0, 12'h000, 1, 1, 12'h222, 12'h6D6, 1, 0, 0, 0, 0);
    step("R5", 0, 12'h000, 1, 1, 12'h222, 12'hBEE, 1, 1, 0, 0, 0);
    step("R5", 0, 12'h000, 1, 1, 12'h333, 12'h444, 1, 1, 0, 0, 0);
    // R6 select steering
    step("R6", 0, 12'h000, 1, 1, 12'h333, 12'h444, 1, 1, 1, 0, 0);
    step("R6", 0, 12'h000, 1, 1, 12'h333, 12'h444, 1, 1, 0, 0, 0);
    step("R6", 0, 12'h000, 1, 1, 12'h333, 12'h444, 1, 1, 1, 0, 0);
    // R7 all enable combinations
    step("R7", 0, 12'h000, 1, 1, 12'h333, 12'h444, 1, 1, 1, 1, 1);
    step("R7", 0, 12'h000, 1, 1, 12'h333, 12'h444, 1, 1, 0, 1, 0);
    step("R7", 0, 12'h000, 1, 1, 12'h333, 12'h444, 1, 1, 1, 0, 1);
    step("R7", 0, 12'h000, 1, 1, 12'h333, 12'h444, 1, 1, 0, 0, 0);
    // R8 reset clears registers, latches untouched
    step("R8", 1, 12'hFFF, 0, 0, 12'h555, 12'h666, 1, 1, 1, 0, 0);
    step("R8", 0, 12'hFFF, 1, 1, 12'h555, 12'h666, 1, 1, 0, 0, 0);
    // R1 after reset
    step("R1", 0, 12'h0F0, 0, 1, 12'h555, 12'h666, 1, 1, 0, 0, 0);
    step("R1", 0, 12'h0F1, 1, 1, 12'h555, 12'h666, 1, 1, 0, 0, 0);
    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule